// File: doc/BRIEF.md
# Coin-Counting Vending Controller

This block is a synchronous state machine that runs a two-drink vending machine. It has three coin inputs worth 5, 10 and 25 cents, one selection button for each drink (regular and diet), and one dispense output for each drink. Both drinks cost 45 cents.

The credit exists only as the current state. There is one state for each reachable amount below the price (0 to 40 cents in steps of 5) and one paid state. No adder or subtractor is used. Every transition is listed explicitly.

Any total of 45 cents or more counts as fully paid, and no change is given back. While the machine is paid it ignores coins and waits for a button. When a button is pressed it releases the chosen drink with a one-cycle pulse and returns to zero credit.

Top module: `vend_ctrl`

## Requirements
- R1: While rst_ni is low, and right after it is released, both dispense outputs are low and the credit is zero, so a full 45 cents is needed before anything is dispensed.
- R2: A coin counts once, on the rising edge of its input. nickel_i is worth 5, dime_i 10 and quarter_i 25 cents. An input held high for several cycles adds its value only once.
- R3: No dispense output goes high while the credit is below 45 cents. At 40 cents, pressing a button dispenses nothing.
- R4: Any coin that brings the total to 45 cents or more puts the machine in the paid state. Totals of 50 or 65 cents buy exactly one drink, and the excess is not kept as credit.
- R5: In the paid state, coin edges are ignored. After the dispense the credit is zero.
- R6: In the paid state, sel_regular_i high at a clock edge makes give_regular_o high for the cycle after that edge, and the credit returns to zero.
- R7: In the paid state, sel_diet_i high (with sel_regular_i low) makes give_diet_o high for the cycle after that edge, and the credit returns to zero.
- R8: If both buttons are high in the paid state, only the regular drink is dispensed.
- R9: A button pressed before the paid state is reached has no effect on the credit or on the outputs.
- R10: If several coin edges arrive at the same clock edge, only the highest-value coin is counted.
- R11: Each dispense pulse is exactly one cycle wide. The two outputs are never high together. A button held high after a dispense gives no second drink without another full payment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nickel_i | input | 1 | 5-cent coin strobe |
| dime_i | input | 1 | 10-cent coin strobe |
| quarter_i | input | 1 | 25-cent coin strobe |
| sel_regular_i | input | 1 | Regular drink button |
| sel_diet_i | input | 1 | Diet drink button |
| give_regular_o | output | 1 | One-cycle release of a regular drink |
| give_diet_o | output | 1 | One-cycle release of a diet drink |

## Verification
The hardest situation to reach is overlapping events: a coin edge that lands while the machine is already paid, at the same clock edge as a button press, or together with other coin edges. A coin input can also still be high from an earlier cycle when a new payment starts.

The stimulus drives these cases on purpose. It drops coins straight after the paid state is entered. It raises all three coin inputs in one cycle. It holds a quarter high across several cycles and holds a button across a dispense. A behavioural credit model running in integers follows every cycle, so any extra or missing count shows up as a wrong dispense cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int NUM_COINS = 3;  // index order: 5c, 10c, 25c (priority rises with index)
  localparam int STATE_W   = 4;

  typedef enum logic [STATE_W-1:0] {
    CR_00, CR_05, CR_10, CR_15, CR_20, CR_25, CR_30, CR_35, CR_40, CR_PAID
  } credit_e;

  typedef enum logic [1:0] {
    COIN_NONE, COIN_5, COIN_10, COIN_25
  } coin_e;
endpackage

// File: rtl/coin_edge.sv
module coin_edge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/coin_pick.sv
module coin_pick
  import vend_pkg::*;
#(
  parameter int N = NUM_COINS
) (
  input  logic [N-1:0] rise_i,
  output coin_e        coin_o
);
  // later (higher-value) index overrides earlier ones
  always_comb begin
    coin_o = COIN_NONE;
    for (int i = 0; i < N; i++) begin
      if (rise_i[i]) coin_o = coin_e'(i + 1);
    end
  end
endmodule

// File: rtl/credit_fsm.sv
module credit_fsm
  import vend_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  coin_e   coin_i,
  input  logic    sel_regular_i,
  input  logic    sel_diet_i,
  output credit_e state_o,
  output logic    give_regular_o,
  output logic    give_diet_o
);
  credit_e state_q, state_d;
  logic    give_r_d, give_d_d;

  function automatic credit_e on_nickel(credit_e s);
    unique case (s)
      CR_00:   return CR_05;
      CR_05:   return CR_10;
      CR_10:   return CR_15;
      CR_15:   return CR_20;
      CR_20:   return CR_25;
      CR_25:   return CR_30;
      CR_30:   return CR_35;
      CR_35:   return CR_40;
      default: return CR_PAID;
    endcase
  endfunction

  function automatic credit_e on_dime(credit_e s);
    unique case (s)
      CR_00:   return CR_10;
      CR_05:   return CR_15;
      CR_10:   return CR_20;
      CR_15:   return CR_25;
      CR_20:   return CR_30;
      CR_25:   return CR_35;
      CR_30:   return CR_40;
      default: return CR_PAID;
    endcase
  endfunction

  function automatic credit_e on_quarter(credit_e s);
    unique case (s)
      CR_00:   return CR_25;
      CR_05:   return CR_30;
      CR_10:   return CR_35;
      CR_15:   return CR_40;
      default: return CR_PAID;
    endcase
  endfunction

  always_comb begin
    state_d  = state_q;
    give_r_d = 1'b0;
    give_d_d = 1'b0;
    if (state_q == CR_PAID) begin
      if (sel_regular_i) begin
        give_r_d = 1'b1;
        state_d  = CR_00;
      end else if (sel_diet_i) begin
        give_d_d = 1'b1;
        state_d  = CR_00;
      end
    end else begin
      unique case (coin_i)
        COIN_5:  state_d = on_nickel(state_q);
        COIN_10: state_d = on_dime(state_q);
        COIN_25: state_d = on_quarter(state_q);
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= CR_00;
      give_regular_o <= 1'b0;
      give_diet_o    <= 1'b0;
    end else begin
      state_q        <= state_d;
      give_regular_o <= give_r_d;
      give_diet_o    <= give_d_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nickel_i,
  input  logic dime_i,
  input  logic quarter_i,
  input  logic sel_regular_i,
  input  logic sel_diet_i,
  output logic give_regular_o,
  output logic give_diet_o
);
  logic [NUM_COINS-1:0] coin_lvl, coin_rise;
  coin_e                coin;
  credit_e              state;

  assign coin_lvl = {quarter_i, dime_i, nickel_i};

  coin_edge #(.N(NUM_COINS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (coin_lvl),
    .rise_o (coin_rise)
  );

  coin_pick #(.N(NUM_COINS)) u_pick (
    .rise_i (coin_rise),
    .coin_o (coin)
  );

  credit_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .coin_i         (coin),
    .sel_regular_i  (sel_regular_i),
    .sel_diet_i     (sel_diet_i),
    .state_o        (state),
    .give_regular_o (give_regular_o),
    .give_diet_o    (give_diet_o)
  );
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
  import vend_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    sel_regular_i,
  input logic    sel_diet_i,
  input logic    give_regular_o,
  input logic    give_diet_o,
  input credit_e state,
  input coin_e   coin
);
  AST_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(give_regular_o && give_diet_o)); // R11

  AST_REG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    give_regular_o |=> !give_regular_o); // R11

  AST_DIET_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    give_diet_o |=> !give_diet_o); // R11

  AST_GIVE_NEEDS_PAID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != CR_PAID) |=> !(give_regular_o || give_diet_o)); // R3

  AST_GIVE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (give_regular_o || give_diet_o) |-> state == CR_00); // R6

  AST_PAID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == CR_PAID && !sel_regular_i && !sel_diet_i) |=> state == CR_PAID); // R5

  AST_REG_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == CR_PAID && sel_regular_i) |=> (give_regular_o && !give_diet_o)); // R8

  AST_DIET_GIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == CR_PAID && !sel_regular_i && sel_diet_i) |=> give_diet_o); // R7

  AST_PRESEL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != CR_PAID && coin == COIN_NONE) |=> $stable(state)); // R9
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sel_regular_i  (sel_regular_i),
  .sel_diet_i     (sel_diet_i),
  .give_regular_o (give_regular_o),
  .give_diet_o    (give_diet_o),
  .state          (state),
  .coin           (coin)
);

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic nickel = 1'b0, dime = 1'b0, quarter = 1'b0;
  logic sel_r = 1'b0, sel_d = 1'b0;
  logic give_r, give_d;

  int checks = 0, errors = 0, cycles = 0;
  int cnt_r = 0, cnt_d = 0;

  // reference model state
  int   m_credit = 0;
  logic m_gr = 1'b0, m_gd = 1'b0;
  logic [2:0] m_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vend_ctrl u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .nickel_i       (nickel),
    .dime_i         (dime),
    .quarter_i      (quarter),
    .sel_regular_i  (sel_r),
    .sel_diet_i     (sel_d),
    .give_regular_o (give_r),
    .give_diet_o    (give_d)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_credit = 0; m_gr = 1'b0; m_gd = 1'b0; m_prev = '0;
    end else begin
      logic [2:0] lv, rise;
      lv   = {quarter, dime, nickel};
      rise = lv & ~m_prev;
      m_gr = 1'b0; m_gd = 1'b0;
      if (m_credit >= 45) begin
        if (sel_r) begin m_gr = 1'b1; m_credit = 0; end
        else if (sel_d) begin m_gd = 1'b1; m_credit = 0; end
      end else begin
        if (rise[2])      m_credit += 25;
        else if (rise[1]) m_credit += 10;
        else if (rise[0]) m_credit += 5;
        if (m_credit > 45) m_credit = 45;
      end
      m_prev = lv;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (give_r) cnt_r++;
    if (give_d) cnt_d++;
    check(give_r === m_gr, m_gr ? "R6" : "R3", "give_regular_o", int'(give_r), int'(m_gr));
    check(give_d === m_gd, m_gd ? "R7" : "R3", "give_diet_o", int'(give_d), int'(m_gd));
    check(!(give_r && give_d), "R11", "both outputs high", 1, 0);
    if (cycles >= MAX_CYCLES) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, MAX_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0: nickel, 1: dime, 2: quarter
  task automatic coin(input int which);
    @(negedge clk);
    case (which)
      0: nickel = 1'b1;
      1: dime = 1'b1;
      default: quarter = 1'b1;
    endcase
    @(negedge clk);
    nickel = 1'b0; dime = 1'b0; quarter = 1'b0;
  endtask

  task automatic press(input bit r, input bit d);
    @(negedge clk);
    sel_r = r; sel_d = d;
    @(negedge clk);
    sel_r = 1'b0; sel_d = 1'b0;
    idle(2);
  endtask

  task automatic expect_cnt(input int r0, input int d0, input int dr, input int dd,
                            input string req);
    check(cnt_r - r0 == dr, req, "regular count", cnt_r - r0, dr);
    check(cnt_d - d0 == dd, req, "diet count", cnt_d - d0, dd);
  endtask

  initial begin
    int r0, d0;
    idle(3);
    check(give_r === 1'b0 && give_d === 1'b0, "R1", "outputs in reset", int'(give_r | give_d), 0);
    rst_ni = 1'b1;
    idle(2);
    check(give_r === 1'b0 && give_d === 1'b0, "R1", "outputs after reset", int'(give_r | give_d), 0);

    // R1/R2: nine nickels buy a regular
    r0 = cnt_r; d0 = cnt_d;
    for (int i = 0; i < 8; i++) coin(0);
    press(1, 0);
    expect_cnt(r0, d0, 0, 0, "R1");
    coin(0);
    press(1, 0);
    expect_cnt(r0, d0, 1, 0, "R2");

    // R2: quarter held high counts once
    r0 = cnt_r; d0 = cnt_d;
    @(negedge clk); quarter = 1'b1;
    idle(5); quarter = 1'b0;
    coin(1);
    press(1, 0);
    expect_cnt(r0, d0, 0, 0, "R2");
    coin(1);
    press(0, 1);
    expect_cnt(r0, d0, 0, 1, "R7");

    // R3: 40 cents is not enough
    r0 = cnt_r; d0 = cnt_d;
    coin(2); coin(1); coin(0);
    press(1, 1);
    expect_cnt(r0, d0, 0, 0, "R3");
    coin(0);
    press(1, 0);
    expect_cnt(r0, d0, 1, 0, "R6");

    // R4: 50 and 65 cents give one drink, no leftover credit
    r0 = cnt_r; d0 = cnt_d;
    coin(2); coin(2);
    press(0, 1);
    press(0, 1);
    expect_cnt(r0, d0, 0, 1, "R4");
    r0 = cnt_r; d0 = cnt_d;
    for (int i = 0; i < 4; i++) coin(1);
    coin(2);
    press(1, 0);
    press(1, 0);
    expect_cnt(r0, d0, 1, 0, "R4");

    // R5: coins dropped while paid are ignored
    r0 = cnt_r; d0 = cnt_d;
    coin(2); coin(1); coin(1);
    coin(2); coin(2); coin(0);
    press(1, 0);
    press(1, 0);
    expect_cnt(r0, d0, 1, 0, "R5");

    // R9: buttons before payment do nothing
    r0 = cnt_r; d0 = cnt_d;
    press(1, 0); press(0, 1);
    coin(2); coin(0); coin(0); coin(0);
    press(1, 1);
    expect_cnt(r0, d0, 0, 0, "R9");
    coin(0);
    press(0, 1);
    expect_cnt(r0, d0, 0, 1, "R9");

    // R10: simultaneous coins count as the highest only
    r0 = cnt_r; d0 = cnt_d;
    @(negedge clk); nickel = 1'b1; dime = 1'b1; quarter = 1'b1;
    @(negedge clk); nickel = 1'b0; dime = 1'b0; quarter = 1'b0;
    coin(1);
    press(1, 0);
    expect_cnt(r0, d0, 0, 0, "R10");
    coin(1);
    press(1, 0);
    expect_cnt(r0, d0, 1, 0, "R10");

    // R8: both buttons in paid state give regular
    r0 = cnt_r; d0 = cnt_d;
    coin(2); coin(2);
    press(1, 1);
    expect_cnt(r0, d0, 1, 0, "R8");

    // R11: held button yields one pulse only
    r0 = cnt_r; d0 = cnt_d;
    coin(2); coin(1); coin(1);
    @(negedge clk); sel_d = 1'b1;
    idle(4); sel_d = 1'b0;
    idle(2);
    expect_cnt(r0, d0, 0, 1, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule